// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This controller serves one processor. It collects fifteen interrupt lines, numbered 1 to 15, and turns each rising edge into a sticky pending bit. Software can also raise interrupts directly through a force register, gate them with a mask, and assign each one to a high or a low priority group. The processor sees one 4-bit request number. This is the highest-numbered active interrupt in the high group or, when that group is empty, in the low group. The processor then acknowledges the interrupt it services by presenting its number on a one-cycle strobe.

Registers sit on a plain 32-bit, word-only bus with an 8-bit byte address. Reads return data one cycle after the access. A broadcast register marks lines whose edges go into the force register instead of the pending register. The force register has two write ports. The first sets and clears bits in one access. The second, an alias, overwrites the whole register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero, `req_level` is 0 and `bus_rdata` is 0.
- R2: Bit 0 is discarded on every write to the level, mask, broadcast, force, alias and clear registers. Line 0 never sets anything. An acknowledge with number 0 changes nothing.
- R3: When line n (1..15) rises and broadcast bit n is 0, pending bit n is set at the next clock edge. A line held high sets pending only once and does not set it again after it is cleared.
- R4: When line n rises and broadcast bit n is 1, force bit n is set and pending bit n is left unchanged.
- R5: The active set is (pending OR force) AND mask. The high group is the active set AND level, and the low group is the active set AND NOT level. `req_level` is the index of the highest set bit in the high group if that group is non-empty, otherwise in the low group, and 0 if both are empty. `req_level` is registered and reflects the register state one cycle later.
- R6: A write to the clear register (offset 0x0C) with data bits 15:1 clears those bits in both pending and force. The clear register always reads 0.
- R7: An acknowledge strobe with number n clears bit n in both pending and force.
- R8: A write at offset 0x80 sets the force bits given in data[15:1] and clears the force bits given in data[31:17]. A write at offset 0x08 replaces the force register with data[15:1]. Both offsets read the force register.
- R9: If a line edge falls in the same cycle as a clear write or an acknowledge of the same bit, the bit ends up set.
- R10: The register offsets are 0x00 level, 0x04 pending, 0x08 force alias, 0x0C clear, 0x10 status, 0x14 broadcast, 0x40 mask and 0x80 force. Pending and status ignore writes. Status and every unlisted address read 0. Read data appears on `bus_rdata` the cycle after the access and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Interrupt lines, bit n is line n, bit 0 unused |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ack_strobe | input | 1 | One-cycle acknowledge |
| ack_num | input | 4 | Number of the acknowledged interrupt |
| req_level | output | 4 | Registered request number, 0 = none |

## Verification
Three sources can hit the same pending or force bit in one cycle: a line edge, a bus write to the clear register and an acknowledge strobe. The bench drives a fresh rising edge in the same cycle as a clear write of that bit. It then does the same with an acknowledge of that bit. Each time it reads the pending register back and expects the bit to remain set. The bench also writes the force register and issues an acknowledge in the same cycle. A behavioural model resolves the write first and the acknowledge after it, and its values are compared with `req_level` and `bus_rdata` on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_LEVEL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_PEND   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_FALIAS = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h10;
  localparam logic [REG_AW-1:0] OFS_BCAST  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h40;
  localparam logic [REG_AW-1:0] OFS_FORCE  = 8'h80;

  // decoded write strobes, one per writable register
  typedef struct packed {
    logic level;
    logic falias;
    logic clear;
    logic bcast;
    logic mask;
    logic force_rmw;
  } wr_dec_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] line_i,
  output logic [NUM_IRQ-1:0] evt_o
);
  localparam logic [NUM_IRQ-1:0] VALID = ~NUM_IRQ'(1);

  logic [NUM_IRQ-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) prev_q[g] <= 1'b0;
        else     prev_q[g] <= line_i[g];
      end
    end
  endgenerate

  // slot 0 does not exist
  assign evt_o = line_i & ~prev_q & VALID;
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               ack_strobe,
  input  logic [IDX_W-1:0]   ack_num,
  output logic [NUM_IRQ-1:0] lvl_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] frc_o,
  output logic [NUM_IRQ-1:0] bcast_o,
  output logic [NUM_IRQ-1:0] msk_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [NUM_IRQ-1:0] VALID = ~NUM_IRQ'(1);

  wr_dec_t dec;
  logic               wr_hit;
  logic [NUM_IRQ-1:0] set_field, clr_field, ack_vec, clr_vec, frc_base;
  logic [NUM_IRQ-1:0] pend_nxt, frc_nxt;
  logic [NUM_IRQ-1:0] lvl_q, pend_q, frc_q, bcast_q, msk_q;

  assign wr_hit    = bus_sel & bus_wr;
  assign set_field = bus_wdata[NUM_IRQ-1:0] & VALID;
  assign clr_field = bus_wdata[HALF +: NUM_IRQ] & VALID;

  always_comb begin
    dec           = '0;
    dec.level     = wr_hit && (bus_addr == OFS_LEVEL);
    dec.falias    = wr_hit && (bus_addr == OFS_FALIAS);
    dec.clear     = wr_hit && (bus_addr == OFS_CLEAR);
    dec.bcast     = wr_hit && (bus_addr == OFS_BCAST);
    dec.mask      = wr_hit && (bus_addr == OFS_MASK);
    dec.force_rmw = wr_hit && (bus_addr == OFS_FORCE);
  end

  always_comb begin
    ack_vec = '0;
    if (ack_strobe) ack_vec = (NUM_IRQ'(1) << ack_num) & VALID;
  end

  // order: bus write, then clear/ack, then line events (set wins)
  always_comb begin
    frc_base = frc_q;
    if (dec.falias)         frc_base = set_field;
    else if (dec.force_rmw) frc_base = (frc_q | set_field) & ~clr_field;
    clr_vec  = ack_vec | (dec.clear ? set_field : '0);
    frc_nxt  = (frc_base & ~clr_vec) | (evt_i & bcast_q);
    pend_nxt = (pend_q & ~clr_vec) | (evt_i & ~bcast_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      pend_q  <= '0;
      frc_q   <= '0;
      bcast_q <= '0;
      msk_q   <= '0;
    end else begin
      pend_q <= pend_nxt;
      frc_q  <= frc_nxt;
      if (dec.level) lvl_q   <= set_field;
      if (dec.bcast) bcast_q <= set_field;
      if (dec.mask)  msk_q   <= set_field;
    end
  end

  assign lvl_o   = lvl_q;
  assign pend_o  = pend_q;
  assign frc_o   = frc_q;
  assign bcast_o = bcast_q;
  assign msk_o   = msk_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] frc_i,
  input  logic [NUM_IRQ-1:0] bcast_i,
  input  logic [NUM_IRQ-1:0] msk_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    unique case (bus_addr)
      OFS_LEVEL:  rd_val = DATA_W'(lvl_i);
      OFS_PEND:   rd_val = DATA_W'(pend_i);
      OFS_FALIAS: rd_val = DATA_W'(frc_i);
      OFS_BCAST:  rd_val = DATA_W'(bcast_i);
      OFS_MASK:   rd_val = DATA_W'(msk_i);
      OFS_FORCE:  rd_val = DATA_W'(frc_i);
      default:    rd_val = '0;  // clear, status, unmapped
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdata_o <= '0;
    else if (bus_sel && !bus_wr) rdata_o <= rd_val;
    else                       rdata_o <= '0;
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM_IRQ = 16,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] frc_i,
  input  logic [NUM_IRQ-1:0] msk_i,
  input  logic [NUM_IRQ-1:0] lvl_i,
  output logic [IDX_W-1:0]   req_o
);
  logic [NUM_IRQ-1:0] active, grp_hi, grp_lo, chosen;
  logic [IDX_W-1:0]   top_idx;

  assign active = (pend_i | frc_i) & msk_i;
  assign grp_hi = active & lvl_i;
  assign grp_lo = active & ~lvl_i;
  assign chosen = (|grp_hi) ? grp_hi : grp_lo;

  // later (higher) index overrides earlier
  always_comb begin
    top_idx = '0;
    for (int i = 1; i < NUM_IRQ; i++)
      if (chosen[i]) top_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= '0;
    else     req_o <= top_idx;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               ack_strobe,
  input  logic [IDX_W-1:0]   ack_num,
  output logic [IDX_W-1:0]   req_level
);
  logic [NUM_IRQ-1:0] evt, lvl_q, pend_q, frc_q, bcast_q, msk_q;

  irq_edge_detect #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk(clk), .rst(rst), .line_i(irq_in), .evt_o(evt)
  );

  irq_state_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .evt_i(evt), .ack_strobe(ack_strobe), .ack_num(ack_num),
    .lvl_o(lvl_q), .pend_o(pend_q), .frc_o(frc_q), .bcast_o(bcast_q), .msk_o(msk_q)
  );

  irq_read_mux #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .lvl_i(lvl_q), .pend_i(pend_q), .frc_i(frc_q), .bcast_i(bcast_q), .msk_i(msk_q),
    .rdata_o(bus_rdata)
  );

  irq_prio_select #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst(rst),
    .pend_i(pend_q), .frc_i(frc_q), .msk_i(msk_q), .lvl_i(lvl_q),
    .req_o(req_level)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               ack_strobe,
  input logic [IDX_W-1:0]   ack_num,
  input logic [IDX_W-1:0]   req_level,
  input logic [NUM_IRQ-1:0] evt,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] frc_q,
  input logic [NUM_IRQ-1:0] lvl_q,
  input logic [NUM_IRQ-1:0] msk_q,
  input logic [NUM_IRQ-1:0] bcast_q
);
  // R2
  bit0_absent_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0] && !frc_q[0] && !msk_q[0] && !lvl_q[0]);

  // R3
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (evt & ~bcast_q) != '0 |=> ($past(evt & ~bcast_q) & ~pend_q) == '0);

  // R4
  edge_sets_force_chk: assert property (@(posedge clk) disable iff (rst)
    (evt & bcast_q) != '0 |=> ($past(evt & bcast_q) & ~frc_q) == '0);

  // R5
  req_is_masked_chk: assert property (@(posedge clk) disable iff (rst)
    req_level != '0 |-> (($past(msk_q) >> req_level) & NUM_IRQ'(1)) != '0);

  // R5
  high_group_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_level != '0) && ((($past(lvl_q) >> req_level) & NUM_IRQ'(1)) == '0)
    |-> ($past(pend_q | frc_q) & $past(msk_q) & $past(lvl_q)) == '0);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack_strobe && (ack_num != '0) && ((evt >> ack_num) & NUM_IRQ'(1)) == '0
    |=> (((pend_q | frc_q) >> $past(ack_num)) & NUM_IRQ'(1)) == '0);

  // R10
  pend_readonly_chk: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_wr && (bus_addr == OFS_PEND) && (evt == '0) && !ack_strobe
    |=> $stable(pend_q));

  // R6
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && (bus_addr == OFS_CLEAR || bus_addr == OFS_STATUS)
    |=> bus_rdata == '0);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ack_strobe(ack_strobe), .ack_num(ack_num),
  .req_level(req_level), .evt(evt), .pend_q(pend_q), .frc_q(frc_q),
  .lvl_q(lvl_q), .msk_q(msk_q), .bcast_q(bcast_q)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_strobe = 1'b0;
  logic [3:0]  ack_num = '0;
  logic [3:0]  req_level;

  int compared = 0;
  int mismatched = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_strobe(ack_strobe), .ack_num(ack_num), .req_level(req_level)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] m_lvl, m_pend, m_frc, m_bc, m_msk, m_prev;
  logic [31:0] exp_rd;
  logic [3:0]  exp_req;

  function automatic logic [3:0] ref_req(input logic [15:0] p, f, m, l);
    int best = 0;
    logic [15:0] act = (p | f) & m;
    for (int i = 15; i >= 1; i--)
      if (act[i] && l[i] && best == 0) best = i;
    if (best == 0)
      for (int i = 15; i >= 1; i--)
        if (act[i] && !l[i] && best == 0) best = i;
    return 4'(best);
  endfunction

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_lvl};
      8'h04: return {16'h0, m_pend};
      8'h08, 8'h80: return {16'h0, m_frc};
      8'h14: return {16'h0, m_bc};
      8'h40: return {16'h0, m_msk};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [15:0] ev, clr, lo, hi;
    if (rst) begin
      m_lvl = 0; m_pend = 0; m_frc = 0; m_bc = 0; m_msk = 0; m_prev = 0;
      exp_rd = 0; exp_req = 0;
    end else begin
      exp_req = ref_req(m_pend, m_frc, m_msk, m_lvl);
      exp_rd  = (bus_sel && !bus_wr) ? ref_read(bus_addr) : 32'h0;
      ev  = irq_in & ~m_prev & 16'hFFFE;
      lo  = bus_wdata[15:0] & 16'hFFFE;
      hi  = bus_wdata[31:16] & 16'hFFFE;
      clr = 16'h0;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          8'h00: m_lvl = lo;
          8'h08: m_frc = lo;
          8'h0C: clr = lo;
          8'h14: m_bc = lo;
          8'h40: m_msk = lo;
          8'h80: m_frc = (m_frc | lo) & ~hi;
          default: ;
        endcase
      end
      if (ack_strobe && ack_num != 0) clr[ack_num] = 1'b1;
      m_pend = (m_pend & ~clr) | (ev & ~m_bc);
      m_frc  = (m_frc & ~clr) | (ev & m_bc);
      m_prev = irq_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison (R5 request, R10 read data)
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R5 req_level vs model", {28'h0, req_level}, {28'h0, exp_req});
      check("R10 bus_rdata vs model", bus_rdata, exp_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_in[n] = 1;
    @(negedge clk); irq_in[n] = 0;
  endtask

  task automatic ack(input int n);
    @(negedge clk); ack_strobe = 1; ack_num = 4'(n);
    @(negedge clk); ack_strobe = 0;
  endtask

  task automatic chk_req(input logic [3:0] exp, input string tag);
    @(negedge clk);
    check(tag, {28'h0, req_level}, {28'h0, exp});
  endtask

  initial begin : watchdog
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; cmp_en = 1;

    // R1 reset state
    rd(8'h00, 0, "R1 level");
    rd(8'h04, 0, "R1 pending");
    rd(8'h80, 0, "R1 force");
    rd(8'h40, 0, "R1 mask");
    rd(8'h14, 0, "R1 broadcast");
    chk_req(0, "R1 req");

    // R2 bit 0 dropped
    wr(8'h40, 32'h0000_FFFF);
    rd(8'h40, 32'h0000_FFFE, "R2 mask bit0");
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, 0, "R2 level bit0");
    pulse(0);
    rd(8'h04, 0, "R2 line 0 ignored");

    // R3 edge held high
    @(negedge clk); irq_in[5] = 1;
    rd(8'h04, 32'h20, "R3 pending set");
    chk_req(5, "R5 single low");
    wr(8'h0C, 32'h20);
    rd(8'h04, 0, "R6 clear pending");
    repeat (4) @(negedge clk);
    rd(8'h04, 0, "R3 held line no retrigger");
    irq_in[5] = 0;

    // R5 priority groups, R7 ack
    @(negedge clk); irq_in[3] = 1; irq_in[9] = 1;
    @(negedge clk); irq_in[3] = 0; irq_in[9] = 0;
    rd(8'h04, 32'h208, "R3 two lines");
    chk_req(9, "R5 highest low");
    wr(8'h00, 32'h8);
    chk_req(3, "R5 high group wins");
    ack(3);
    chk_req(9, "R7 ack 3");
    ack(0);
    rd(8'h04, 32'h200, "R2 ack 0 ignored");
    ack(9);
    chk_req(0, "R7 ack 9 empties");

    // R8 force register
    wr(8'h80, 32'h0000_0402);
    rd(8'h08, 32'h402, "R8 force set");
    chk_req(10, "R5 from force");
    wr(8'h80, 32'h0400_0010);
    rd(8'h80, 32'h012, "R8 force set/clear");
    wr(8'h08, 32'h0000_8001);
    rd(8'h80, 32'h8000, "R8 alias replace");
    chk_req(15, "R5 force 15");
    wr(8'h40, 32'h0);
    chk_req(0, "R5 masked");
    wr(8'h40, 32'hFFFE);

    // R4 broadcast routing
    wr(8'h14, 32'h40);
    rd(8'h14, 32'h40, "R4 broadcast readback");
    pulse(6);
    rd(8'h80, 32'h8040, "R4 force via broadcast");
    rd(8'h04, 0, "R4 pending untouched");
    wr(8'h00, 32'h40);
    chk_req(6, "R5 high group 6");

    // R6 clear both
    wr(8'h0C, 32'hFFFF);
    rd(8'h80, 0, "R6 force cleared");
    rd(8'h0C, 0, "R6 clear reads 0");

    // R9 set wins over clear and ack
    pulse(7);
    @(negedge clk);
    irq_in[7] = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h80;
    @(negedge clk); bus_sel = 0; bus_wr = 0; irq_in[7] = 0;
    rd(8'h04, 32'h80, "R9 edge beats clear");
    @(negedge clk); irq_in[7] = 1; ack_strobe = 1; ack_num = 4'd7;
    @(negedge clk); irq_in[7] = 0; ack_strobe = 0;
    rd(8'h04, 32'h80, "R9 edge beats ack");
    ack(7);
    rd(8'h04, 0, "R7 ack 7");

    // write to force and ack in one cycle: write first, then ack clears
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h80; bus_wdata = 32'h0000_0C00;
    ack_strobe = 1; ack_num = 4'd11;
    @(negedge clk); bus_sel = 0; bus_wr = 0; ack_strobe = 0;
    rd(8'h80, 32'h400, "R7 ack after force write");
    wr(8'h0C, 32'hFFFF);

    // R10 read-only and unmapped
    wr(8'h04, 32'hFFFF);
    rd(8'h04, 0, "R10 pending read-only");
    wr(8'h10, 32'hFFFF);
    rd(8'h10, 0, "R10 status reads 0");
    rd(8'h24, 0, "R10 unmapped");
    rd(8'h44, 0, "R10 second mask slot");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule